// File: doc/BRIEF.md
# Hardware/Software Selectable Clock Gate Controller

This block decides, for a single clock, whether that clock runs. It holds a small control register that software loads through a parallel write strobe. One bit of that register hands gating control either to an automatic request input driven by other hardware, or to a software enable bit. The resulting decision leaves the block as a registered clock-enable signal, meant to drive a separate glitch-free gating cell.

A read-only status bit reports the gate state that has settled. It copies the clock-enable only after the enable has held steady for a settle window. The window is 2 cycles with hysteresis off, 8 cycles with short hysteresis and 32 cycles with long hysteresis. Any change of the enable during a pending window starts the window again. Software writes the control register and then polls the status bit to learn that the change has completed. A build-time variant keeps the clock running whenever software owns the gate.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the control word reads 4'b0011 (software mode, enable set, hysteresis off), and clk_en_o and status_o are both 1.
- R2: When load_i is high at a rising edge, load_data_i is stored and appears on ctrl_o after that edge. Without load_i, ctrl_o holds its value whatever load_data_i does.
- R3: Control bit 1 set to 1 selects software mode. In software mode clk_en_o takes the value of control bit 0 (1 runs, 0 stops) one edge after the register holds it, and hw_req_i has no effect.
- R4: Control bit 1 cleared to 0 selects hardware mode. In hardware mode clk_en_o takes the value of hw_req_i sampled at the previous edge, and control bit 0 has no effect.
- R5: With control bit 2 (hysteresis enable) at 0, status_o takes a new clk_en_o value 2 edges after clk_en_o changed.
- R6: With control bit 2 at 1 and control bit 3 (hysteresis length) at 0, status_o takes a new clk_en_o value 8 edges after the change.
- R7: With control bit 2 at 1 and control bit 3 at 1, status_o takes a new clk_en_o value 32 edges after the change.
- R8: A change of clk_en_o while a settle window is pending restarts that window. A clk_en_o pulse shorter than the window never reaches status_o.
- R9: With NO_DISABLE=1, software mode forces clk_en_o to 1 whatever control bit 0 holds. Hardware mode still follows hw_req_i.
- R10: status_o changes only to the value clk_en_o holds at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Control register load strobe |
| load_data_i | input | 4 | Control word: bit0 enable, bit1 software select, bit2 hysteresis enable, bit3 long hysteresis |
| hw_req_i | input | 1 | Automatic gating request used in hardware mode |
| ctrl_o | output | 4 | Current control word |
| clk_en_o | output | 1 | Registered clock enable for the gating cell |
| status_o | output | 1 | Settled gate state for software polling |

## Verification
The bench builds two copies side by side, both with the default settle windows of 2, 8 and 32 cycles. One copy has NO_DISABLE=0 and the other has NO_DISABLE=1, so the forced-on software mode can be compared against the normal one under identical stimulus. The default windows are short enough that each window length can be checked on the exact edge before and the exact edge of the status change. A mid-window restart on the 32-cycle window gives a clear split between a counter that restarts and one that does not.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic hys_long;  // bit3
    logic hys_en;    // bit2
    logic sw_sel;    // bit1: 1 software, 0 hardware
    logic en;        // bit0
  } gate_ctrl_t;

  localparam gate_ctrl_t CTRL_RST = '{hys_long: 1'b0, hys_en: 1'b0, sw_sel: 1'b1, en: 1'b1};
endpackage

// File: rtl/gate_ctrl_reg.sv
module gate_ctrl_reg
  import clk_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] data_i,
  output gate_ctrl_t        ctrl_o
);
  gate_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (load_i) ctrl_q <= gate_ctrl_t'(data_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/gate_mode_mux.sv
module gate_mode_mux
  import clk_gate_pkg::*;
#(
  parameter bit NO_DISABLE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  gate_ctrl_t ctrl_i,
  input  logic       hw_req_i,
  output logic       gate_nxt_o,
  output logic       gate_o
);
  logic sw_val;
  logic gate_q;

  generate
    if (NO_DISABLE) begin : g_force_on
      assign sw_val = 1'b1;
    end else begin : g_sw_en
      assign sw_val = ctrl_i.en;
    end
  endgenerate

  assign gate_nxt_o = ctrl_i.sw_sel ? sw_val : hw_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else gate_q <= gate_nxt_o;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/gate_status_dly.sv
module gate_status_dly #(
  parameter int DLY_OFF   = 2,
  parameter int DLY_SHORT = 8,
  parameter int DLY_LONG  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hys_en_i,
  input  logic hys_long_i,
  input  logic gate_i,
  input  logic gate_nxt_i,
  output logic status_o
);
  localparam int DLY_MAX_A = (DLY_OFF > DLY_SHORT) ? DLY_OFF : DLY_SHORT;
  localparam int DLY_MAX   = (DLY_MAX_A > DLY_LONG) ? DLY_MAX_A : DLY_LONG;
  localparam int CNT_W     = $clog2(DLY_MAX + 1);
  localparam logic [CNT_W-1:0] SAT      = CNT_W'(DLY_MAX);
  localparam logic [CNT_W-1:0] OFF_M1   = CNT_W'(DLY_OFF - 1);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(DLY_SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(DLY_LONG - 1);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] lim;
  logic             status_q;

  // edges the enable must stay put, less one
  always_comb begin
    if (!hys_en_i) lim = OFF_M1;
    else if (hys_long_i) lim = LONG_M1;
    else lim = SHORT_M1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= SAT;
      status_q <= 1'b1;
    end else if (gate_nxt_i != gate_i) begin
      run_q <= '0;  // restart window
    end else begin
      if (run_q != SAT) run_q <= run_q + 1'b1;
      if (run_q >= lim) status_q <= gate_i;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter bit NO_DISABLE = 1'b0,
  parameter int DLY_OFF    = 2,
  parameter int DLY_SHORT  = 8,
  parameter int DLY_LONG   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] load_data_i,
  input  logic              hw_req_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              clk_en_o,
  output logic              status_o
);
  gate_ctrl_t ctrl;
  logic       gate_nxt;
  logic       gate;

  gate_ctrl_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .data_i (load_data_i),
    .ctrl_o (ctrl)
  );

  gate_mode_mux #(.NO_DISABLE(NO_DISABLE)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .hw_req_i   (hw_req_i),
    .gate_nxt_o (gate_nxt),
    .gate_o     (gate)
  );

  gate_status_dly #(
    .DLY_OFF   (DLY_OFF),
    .DLY_SHORT (DLY_SHORT),
    .DLY_LONG  (DLY_LONG)
  ) u_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hys_en_i   (ctrl.hys_en),
    .hys_long_i (ctrl.hys_long),
    .gate_i     (gate),
    .gate_nxt_i (gate_nxt),
    .status_o   (status_o)
  );

  assign ctrl_o   = ctrl;
  assign clk_en_o = gate;
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk #(
  parameter bit NO_DISABLE = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       load_i,
  input logic [3:0] load_data_i,
  input logic       hw_req_i,
  input logic [3:0] ctrl_o,
  input logic       clk_en_o,
  input logic       status_o
);
  // R1
  rst_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (ctrl_o == 4'b0011 && clk_en_o && status_o));

  // R2
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ctrl_o == $past(load_data_i));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ctrl_o));

  // R3 R9
  sw_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[1] |=> clk_en_o == (NO_DISABLE ? 1'b1 : $past(ctrl_o[0])));

  // R4
  hw_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[1] |=> clk_en_o == $past(hw_req_i));

  // R5
  fast_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(status_o) && !$past(ctrl_o[2])) |->
      (clk_en_o == $past(clk_en_o) && clk_en_o == $past(clk_en_o, 2)));

  // R10
  status_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o) |-> status_o == clk_en_o);
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(.NO_DISABLE(NO_DISABLE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .load_data_i (load_data_i),
  .hw_req_i    (hw_req_i),
  .ctrl_o      (ctrl_o),
  .clk_en_o    (clk_en_o),
  .status_o    (status_o)
);

// File: tb/sim_clk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_clk_gate_ctrl;
  localparam int K_CTRL = 0;
  localparam int K_EN   = 1;
  localparam int K_ST   = 2;

  typedef struct {
    int       due;
    int       inst;
    int       kind;
    logic [3:0] val;
    string    req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] ldata = 4'h0;
  logic       hw_req = 1'b0;
  logic [3:0] ctrl0, ctrl1;
  logic       en0, en1, st0, st1;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_gate_ctrl #(.NO_DISABLE(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_data_i(ldata),
    .hw_req_i(hw_req), .ctrl_o(ctrl0), .clk_en_o(en0), .status_o(st0));

  clk_gate_ctrl #(.NO_DISABLE(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_data_i(ldata),
    .hw_req_i(hw_req), .ctrl_o(ctrl1), .clk_en_o(en1), .status_o(st1));

  task automatic expect_at(int dly, int inst, int kind, logic [3:0] v, string req);
    item_t it;
    it.due = cyc + dly; it.inst = inst; it.kind = kind; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] v);
    load = 1'b1; ldata = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  // monitor: pops due items and compares
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [3:0] act;
        case (sb[i].kind)
          K_CTRL:  act = (sb[i].inst == 0) ? ctrl0 : ctrl1;
          K_EN:    act = {3'b0, (sb[i].inst == 0) ? en0 : en1};
          default: act = {3'b0, (sb[i].inst == 0) ? st0 : st1};
        endcase
        n_chk++;
        if (act !== sb[i].val) begin
          n_fail++;
          $display("FAIL %s u%0d kind %0d cycle %0d: actual %h expected %h",
                   sb[i].req, sb[i].inst, sb[i].kind, cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    for (int u = 0; u < 2; u++) begin
      expect_at(1, u, K_CTRL, 4'b0011, "R1");
      expect_at(1, u, K_EN, 4'd1, "R1");
      expect_at(1, u, K_ST, 4'd1, "R1");
    end
    tick(2);

    // R2 R3 R5 R9: software mode, enable cleared, hysteresis off
    expect_at(1, 0, K_CTRL, 4'b0010, "R2");
    expect_at(1, 0, K_EN, 4'd1, "R3");
    expect_at(2, 0, K_EN, 4'd0, "R3");
    expect_at(3, 0, K_ST, 4'd1, "R5");
    expect_at(4, 0, K_ST, 4'd0, "R5");
    expect_at(2, 1, K_EN, 4'd1, "R9");
    expect_at(4, 1, K_ST, 4'd1, "R9");
    wr(4'b0010);
    tick(5);

    // R3 hw_req_i ignored in software mode
    hw_req = 1'b1;
    expect_at(1, 0, K_EN, 4'd0, "R3");
    expect_at(3, 0, K_EN, 4'd0, "R3");
    expect_at(3, 0, K_ST, 4'd0, "R3");
    tick(4);
    hw_req = 1'b0;

    // R2 data without strobe is ignored
    ldata = 4'hF;
    expect_at(2, 0, K_CTRL, 4'b0010, "R2");
    expect_at(2, 1, K_CTRL, 4'b0010, "R2");
    tick(3);

    // R4 R9 hardware mode, enable bit set but ignored
    expect_at(1, 0, K_CTRL, 4'b0001, "R2");
    expect_at(2, 0, K_EN, 4'd0, "R4");
    expect_at(2, 1, K_EN, 4'd0, "R9");
    wr(4'b0001);
    tick(3);
    hw_req = 1'b1;
    expect_at(1, 0, K_EN, 4'd1, "R4");
    expect_at(1, 1, K_EN, 4'd1, "R9");
    expect_at(2, 0, K_ST, 4'd0, "R5");
    expect_at(3, 0, K_ST, 4'd1, "R5");
    tick(5);

    // R6 short hysteresis
    wr(4'b0100);
    tick(3);
    hw_req = 1'b0;
    expect_at(1, 0, K_EN, 4'd0, "R4");
    expect_at(8, 0, K_ST, 4'd1, "R6");
    expect_at(9, 0, K_ST, 4'd0, "R6");
    expect_at(9, 1, K_ST, 4'd0, "R6");
    tick(11);

    // R7 long hysteresis
    wr(4'b1100);
    tick(3);
    hw_req = 1'b1;
    expect_at(1, 0, K_EN, 4'd1, "R7");
    expect_at(32, 0, K_ST, 4'd0, "R7");
    expect_at(33, 0, K_ST, 4'd1, "R7");
    tick(35);

    // R8 restart of the window and pulse shorter than window
    hw_req = 1'b0;
    expect_at(1, 0, K_EN, 4'd0, "R8");
    expect_at(12, 0, K_EN, 4'd1, "R8");
    expect_at(40, 0, K_ST, 4'd1, "R8");
    expect_at(53, 0, K_ST, 4'd1, "R8");
    expect_at(54, 0, K_ST, 4'd0, "R8");
    tick(11);
    hw_req = 1'b1;
    tick(10);
    hw_req = 1'b0;
    tick(36);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule